// File: doc/BRIEF.md
# Error Record Status Register

This block holds the primary status word of one hardware error record. Detectors elsewhere in the chip report errors on a one-cycle report port. Each report carries a class (corrected, deferred or uncorrected), a corrected-error kind, an uncorrected-error type, a poison flag, an in-band-report flag, two flags that say whether the companion address and extra-information registers hold data, and two 8-bit codes (primary and secondary). The register keeps the syndrome of the most severe error seen and flags overflow when errors of the same severity pile up. It also keeps one sticky flag per class.

Software reads the whole 64-bit word on a read port and updates it through a single-cycle write strobe. Most status flags are write-one-to-clear. Each field ignores a write unless the write also clears the fields that protect it. Because of this, an error that lands between a software read and the following clear is never erased.

Top module: `err_syndrome_reg`

## Requirements
- R1: After reset every bit of the read word is 0.
- R2: The read word places address-valid at bit 31, valid at 30, uncorrected at 29, reported at 28, overflow at 27, info-valid at 26, the corrected field at 25:24, deferred at 23, poison at 22, the uncorrected-type field at 21:20, the secondary code at 15:8 and the primary code at 7:0. Bits 63:32 and 19:16 always read 0, whatever was written.
- R3: Single-bit flags clear when 1 is written to them, and writing 0 leaves them unchanged. A 2-bit flag field clears only when 11 is written to it. Writing 01 or 10 leaves it unchanged.
- R4: A corrected report with kind 01 (transient), 10 (plain) or 11 (persistent) stores that kind in the corrected field. Kind 00 means the kind is unknown and stores 10.
- R5: Overflow is set in three cases. An uncorrected report arrives while the uncorrected flag is 1. A deferred report arrives while uncorrected is 0 and deferred is 1. A corrected report arrives while uncorrected and deferred are 0 and the corrected field is nonzero.
- R6: While overflow is 1, writes to the uncorrected, deferred and corrected fields are ignored, unless the same write sets bit 27 to clear overflow.
- R7: A write of 1 to valid is ignored while any of uncorrected, deferred or the corrected field is nonzero and is not cleared by that same write.
- R8: Writes to address-valid, info-valid, reported, poison, uncorrected-type and both codes are ignored unless the highest nonzero class field is cleared by the same write. Class priority is uncorrected, then deferred, then corrected.
- R9: Each class is encoded on the class input as 01 corrected, 10 deferred and 11 uncorrected. A report whose class ranks at or above the highest class already held overwrites the whole syndrome. The syndrome is the codes, poison, type, reported, address-valid and info-valid. Uncorrected reports load their type; other classes load type 00. Corrected reports load poison 0. A lower-ranked report only sets its own class flag.
- R10: Every report with a nonzero class sets valid. A report with class 00 changes nothing.
- R11: When a report and a software write arrive in the same cycle, the write is applied first and the report is then recorded on top of its result.
- R12: When the code fields are not protected, a write loads them with bits 15:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_wr | input | 1 | Software write strobe, one cycle per write |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Current register contents |
| err_valid | input | 1 | Error report strobe |
| err_class | input | 2 | Error class: 01 corrected, 10 deferred, 11 uncorrected |
| err_ce_kind | input | 2 | Corrected kind: 00 unknown, 01 transient, 10 plain, 11 persistent |
| err_ut | input | 2 | Uncorrected type: 00 uncontainable, 01 unrecoverable, 10 restartable, 11 recoverable |
| err_poison | input | 1 | Error caused by poisoned data |
| err_reported | input | 1 | Error was signalled in band to the requester |
| err_addr_ok | input | 1 | Companion address register holds data for this error |
| err_info_ok | input | 1 | Companion information registers hold data for this error |
| err_primary | input | 8 | Primary error code (for example 0x02 memory ECC, 0x13 external timeout) |
| err_secondary | input | 8 | Secondary, block-specific error code |

## Verification
The software write port and the error report port can fire in the same cycle. This is the race the protection rules exist for. The bench provokes it twice. In the first case, a write clears the uncorrected flag and a new uncorrected report lands in the same cycle. The result must show the flag set again, the new syndrome in place, and no overflow. In the second case, overflow is set and a clear without the overflow bit meets a deferred report. The write must be ignored, and the deferred flag must be added without touching the held syndrome.

// File: rtl/errsyn_pkg.sv
package errsyn_pkg;

  localparam int REG_W  = 64;
  localparam int CODE_W = 8;
  localparam int LOW_W  = 32;
  localparam int HI_W   = REG_W - LOW_W;
  localparam int RSV_W  = 4;

  // bit positions inside the software-visible word
  localparam int P_AV  = 31;
  localparam int P_V   = 30;
  localparam int P_UE  = 29;
  localparam int P_ER  = 28;
  localparam int P_OF  = 27;
  localparam int P_MV  = 26;
  localparam int P_CE  = 24;
  localparam int P_DE  = 23;
  localparam int P_PN  = 22;
  localparam int P_UT  = 20;
  localparam int P_SEC = 8;
  localparam int P_PRI = 0;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_CE   = 2'b01,
    CLS_DE   = 2'b10,
    CLS_UE   = 2'b11
  } err_cls_e;

  typedef struct packed {
    logic              av;
    logic              v;
    logic              ue;
    logic              er;
    logic              of;
    logic              mv;
    logic [1:0]        ce;
    logic              de;
    logic              pn;
    logic [1:0]        ut;
    logic [CODE_W-1:0] sec;
    logic [CODE_W-1:0] pri;
  } stat_t;

  typedef struct packed {
    err_cls_e          cls;
    logic [1:0]        kind;
    logic [1:0]        ut;
    logic              pn;
    logic              er;
    logic              av;
    logic              mv;
    logic [CODE_W-1:0] pri;
    logic [CODE_W-1:0] sec;
  } evt_t;

  // rank of the most severe class currently held: 3 ue, 2 de, 1 ce, 0 none
  function automatic logic [1:0] held_rank(input stat_t s);
    if (s.ue)            return 2'd3;
    else if (s.de)       return 2'd2;
    else if (s.ce != 0)  return 2'd1;
    else                 return 2'd0;
  endfunction

  // rank of an incoming class is its own encoding
  function automatic logic [1:0] cls_rank(input err_cls_e c);
    return logic'(c[1]) ? {1'b1, c[0]} : {1'b0, c[0]};
  endfunction

  // corrected kind to field value; unknown kind maps to plain corrected
  function automatic logic [1:0] ce_code(input logic [1:0] kind);
    return (kind == 2'b00) ? 2'b10 : kind;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input stat_t s);
    return {{HI_W{1'b0}}, s.av, s.v, s.ue, s.er, s.of, s.mv, s.ce,
            s.de, s.pn, s.ut, {RSV_W{1'b0}}, s.sec, s.pri};
  endfunction

endpackage

// File: rtl/errsyn_swwrite.sv
module errsyn_swwrite
  import errsyn_pkg::*;
(
  input  stat_t            cur,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output stat_t            nxt,
  output logic             ue_clr,
  output logic             de_clr,
  output logic             ce_clr,
  output logic             hp_clr,
  output logic             v_ok
);

  logic class_open;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-1:LOW_W], wdata[P_UT-1:P_SEC+CODE_W]};

  // class fields accept a clear only while overflow is 0 or being cleared
  assign class_open = !cur.of || wdata[P_OF];

  always_comb begin
    ue_clr = wr_en && wdata[P_UE] && cur.ue && class_open;
    de_clr = wr_en && wdata[P_DE] && cur.de && class_open;
    ce_clr = wr_en && (&wdata[P_CE +: 2]) && (cur.ce != 2'b00) && class_open;
  end

  // the most severe nonzero class guards the syndrome fields
  always_comb begin
    if (cur.ue)            hp_clr = ue_clr;
    else if (cur.de)       hp_clr = de_clr;
    else if (cur.ce != 0)  hp_clr = ce_clr;
    else                   hp_clr = wr_en;
  end

  // valid may only drop once every nonzero class field drops with it
  assign v_ok = (!cur.ue || ue_clr) && (!cur.de || de_clr) &&
                ((cur.ce == 2'b00) || ce_clr);

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      if (wdata[P_OF]) nxt.of = 1'b0;
      if (ue_clr)      nxt.ue = 1'b0;
      if (de_clr)      nxt.de = 1'b0;
      if (ce_clr)      nxt.ce = 2'b00;
      if (wdata[P_V] && v_ok) nxt.v = 1'b0;
      if (hp_clr) begin
        if (wdata[P_AV]) nxt.av = 1'b0;
        if (wdata[P_MV]) nxt.mv = 1'b0;
        if (wdata[P_ER]) nxt.er = 1'b0;
        if (wdata[P_PN]) nxt.pn = 1'b0;
        if (&wdata[P_UT +: 2]) nxt.ut = 2'b00;
        nxt.sec = wdata[P_SEC +: CODE_W];
        nxt.pri = wdata[P_PRI +: CODE_W];
      end
    end
  end

endmodule

// File: rtl/errsyn_capture.sv
module errsyn_capture
  import errsyn_pkg::*;
(
  input  stat_t mid,
  input  logic  fire,
  input  evt_t  evt,
  output stat_t nxt,
  output logic  ovf_hit,
  output logic  take
);

  logic [1:0] rank_now;
  logic [1:0] rank_new;
  logic       is_ue;
  logic       is_de;
  logic       is_ce;

  assign rank_now = held_rank(mid);
  assign rank_new = cls_rank(evt.cls);
  assign is_ue    = fire && (evt.cls == CLS_UE);
  assign is_de    = fire && (evt.cls == CLS_DE);
  assign is_ce    = fire && (evt.cls == CLS_CE);

  assign ovf_hit = (is_ue && mid.ue) ||
                   (is_de && !mid.ue && mid.de) ||
                   (is_ce && !mid.ue && !mid.de && (mid.ce != 2'b00));

  assign take = fire && (rank_new >= rank_now);

  always_comb begin
    nxt = mid;
    if (fire) begin
      nxt.v = 1'b1;
      if (is_ue) nxt.ue = 1'b1;
      if (is_de) nxt.de = 1'b1;
      if (is_ce) nxt.ce = ce_code(evt.kind);
      if (ovf_hit) nxt.of = 1'b1;
      if (take) begin
        nxt.pri = evt.pri;
        nxt.sec = evt.sec;
        nxt.av  = evt.av;
        nxt.mv  = evt.mv;
        nxt.er  = evt.er;
        nxt.pn  = is_ce ? 1'b0 : evt.pn;
        nxt.ut  = is_ue ? evt.ut : 2'b00;
      end
    end
  end

endmodule

// File: rtl/err_syndrome_reg.sv
module err_syndrome_reg
  import errsyn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata,
  input  logic              err_valid,
  input  logic [1:0]        err_class,
  input  logic [1:0]        err_ce_kind,
  input  logic [1:0]        err_ut,
  input  logic              err_poison,
  input  logic              err_reported,
  input  logic              err_addr_ok,
  input  logic              err_info_ok,
  input  logic [CODE_W-1:0] err_primary,
  input  logic [CODE_W-1:0] err_secondary
);

  stat_t q;
  stat_t mid;
  stat_t nxt;
  evt_t  evt;
  logic  evt_fire;
  logic  ue_clr, de_clr, ce_clr, hp_clr, v_ok;
  logic  ovf_hit, take;

  assign evt = '{cls:  err_cls_e'(err_class),
                 kind: err_ce_kind,
                 ut:   err_ut,
                 pn:   err_poison,
                 er:   err_reported,
                 av:   err_addr_ok,
                 mv:   err_info_ok,
                 pri:  err_primary,
                 sec:  err_secondary};

  assign evt_fire = err_valid && (err_class != CLS_NONE);

  // software write first, then the report lands on the result
  errsyn_swwrite u_wr (
    .cur    (q),
    .wr_en  (sw_wr),
    .wdata  (sw_wdata),
    .nxt    (mid),
    .ue_clr (ue_clr),
    .de_clr (de_clr),
    .ce_clr (ce_clr),
    .hp_clr (hp_clr),
    .v_ok   (v_ok)
  );

  errsyn_capture u_cap (
    .mid     (mid),
    .fire    (evt_fire),
    .evt     (evt),
    .nxt     (nxt),
    .ovf_hit (ovf_hit),
    .take    (take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign sw_rdata = pack_word(q);

  a_r10_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |=> q.v);

  a_r5_ue_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && err_class == CLS_UE && mid.ue) |=> q.of);

  a_r6_class_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && q.of && !sw_wdata[P_OF] && !evt_fire) |=>
      (q.ue == $past(q.ue) && q.de == $past(q.de) && q.ce == $past(q.ce)));

  a_r9_low_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && !take) |=>
      (q.pri == $past(mid.pri) && q.sec == $past(mid.sec)));

  a_r4_ce_default: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && err_class == CLS_CE && err_ce_kind == 2'b00) |=> q.ce == 2'b10);

  a_r3_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata[LOW_W-1:P_UT] == '0 && !evt_fire) |=>
      ({q.av, q.v, q.ue, q.er, q.of, q.mv, q.ce, q.de, q.pn, q.ut} ==
       $past({q.av, q.v, q.ue, q.er, q.of, q.mv, q.ce, q.de, q.pn, q.ut})));

  a_r7_valid_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && q.ue && !ue_clr && !evt_fire) |=> q.v == $past(q.v));

endmodule

// File: tb/err_syndrome_reg_test.sv
`timescale 1ns/1ps
module err_syndrome_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] sw_rdata;
  logic        err_valid = 1'b0;
  logic [1:0]  err_class = '0;
  logic [1:0]  err_ce_kind = '0;
  logic [1:0]  err_ut = '0;
  logic        err_poison = 1'b0;
  logic        err_reported = 1'b0;
  logic        err_addr_ok = 1'b0;
  logic        err_info_ok = 1'b0;
  logic [7:0]  err_primary = '0;
  logic [7:0]  err_secondary = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  err_syndrome_reg uut (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .err_valid(err_valid), .err_class(err_class),
    .err_ce_kind(err_ce_kind), .err_ut(err_ut), .err_poison(err_poison),
    .err_reported(err_reported), .err_addr_ok(err_addr_ok),
    .err_info_ok(err_info_ok), .err_primary(err_primary),
    .err_secondary(err_secondary)
  );

  typedef struct packed {
    bit        wr;
    bit [31:0] wd;
    bit        ev;
    bit [1:0]  cls;
    bit [1:0]  kind;
    bit [1:0]  ut;
    bit        pn;
    bit        er;
    bit        av;
    bit        mv;
    bit [7:0]  pri;
    bit [7:0]  sec;
    bit [31:0] expv;
    bit [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R4 R10: unknown-kind corrected error into empty record
    '{1'b0, 32'h0, 1'b1, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 8'h11, 32'hC200_1102, 8'd4},
    // R5: second corrected error overflows, transient kind
    '{1'b0, 32'h0, 1'b1, 2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h00, 32'h4900_0005, 8'd5},
    // R6: corrected clear ignored under overflow
    '{1'b1, 32'h0300_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h4900_0005, 8'd6},
    // R6 R12: clear with overflow bit; codes now writable
    '{1'b1, 32'h0B00_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h4000_0000, 8'd6},
    // R7: valid clears once no class field is set
    '{1'b1, 32'h4000_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_0000, 8'd7},
    // R9: deferred error, type input not loaded
    '{1'b0, 32'h0, 1'b1, 2'b10, 2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 8'h17, 8'h20, 32'hD4C0_2017, 8'd9},
    // R9: lower corrected error only adds its flag, no overflow
    '{1'b0, 32'h0, 1'b1, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 8'h01, 32'hD7C0_2017, 8'd9},
    // R5: second deferred error overflows and overwrites
    '{1'b0, 32'h0, 1'b1, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h18, 8'h33, 32'h4B80_3318, 8'd5},
    // R7 R6: valid and deferred clear both blocked
    '{1'b1, 32'h4080_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h4B80_3318, 8'd7},
    // R7: deferred cleared, corrected still set keeps valid
    '{1'b1, 32'h4880_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h4300_0000, 8'd7},
    // R3: partial 01 write to corrected field has no effect
    '{1'b1, 32'h4100_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h4300_0000, 8'd3},
    // R3: 11 clears corrected, valid follows
    '{1'b1, 32'h4300_0000, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_0000, 8'd3},
    // R9: uncorrected error loads type
    '{1'b0, 32'h0, 1'b1, 2'b11, 2'b00, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'h13, 8'h44, 32'hF070_4413, 8'd9},
    // R8: syndrome write without clearing uncorrected is ignored
    '{1'b1, 32'h9070_FFFF, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'hF070_4413, 8'd8},
    // R11: clear of uncorrected meets new uncorrected error
    '{1'b1, 32'h2000_0000, 1'b1, 2'b11, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h14, 8'h55, 32'h6410_5514, 8'd11},
    // R5: repeat uncorrected error overflows, overwrites
    '{1'b0, 32'h0, 1'b1, 2'b11, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 8'h66, 32'hE820_6602, 8'd5},
    // R11: locked clear meets lower deferred error
    '{1'b1, 32'h2000_0000, 1'b1, 2'b10, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h15, 8'h00, 32'hE8A0_6602, 8'd11},
    // R2: all-ones write clears flags, reserved bits stay 0
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_FFFF, 8'd2},
    // R12: free code write
    '{1'b1, 32'h0000_A5C3, 1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_A5C3, 8'd12},
    // R10: class 00 report is ignored
    '{1'b0, 32'h0, 1'b1, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h77, 8'h77, 32'h0000_A5C3, 8'd10}
  };

  task automatic check(input logic [63:0] expv, input int req);
    n_chk++;
    if (sw_rdata !== expv) begin
      n_bad++;
      $display("FAIL R%0d: read %h expected %h", req, sw_rdata, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(64'h0, 1); // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sw_wr         = VECS[i].wr;
      sw_wdata      = {32'hFFFF_FFFF, VECS[i].wd}; // R2 upper write bits ignored
      err_valid     = VECS[i].ev;
      err_class     = VECS[i].cls;
      err_ce_kind   = VECS[i].kind;
      err_ut        = VECS[i].ut;
      err_poison    = VECS[i].pn;
      err_reported  = VECS[i].er;
      err_addr_ok   = VECS[i].av;
      err_info_ok   = VECS[i].mv;
      err_primary   = VECS[i].pri;
      err_secondary = VECS[i].sec;
      @(negedge clk);
      sw_wr     = 1'b0;
      err_valid = 1'b0;
      check({32'h0, VECS[i].expv}, int'(VECS[i].req));
    end
    // R1: reset in the middle of a populated record
    rst_n = 1'b0;
    @(negedge clk);
    check(64'h0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule